// File: doc/BRIEF.md
# Write-Order Sequenced Multiply/Divide Coprocessor

This block is an arithmetic helper that sits on a byte-wide register port of a small microcontroller. It holds six operand bytes, a shift-control byte and a status byte. The operation is not chosen by an opcode. The decoder watches the order in which software writes the operand bytes, and the write that completes a known order launches the computation. Four operations are available: a 32-bit by 16-bit divide, a 16-bit by 16-bit divide, a 16x16 multiply, and a 32-bit shift or normalize.

Once launched, the unit runs by itself and handles one bit of the operation per clock. It writes its results back into the same operand bytes, where software reads them. Three flags report the outcome. Done marks a finished calculation. Overflow marks a divide by zero, a product wider than 16 bits, or a normalize that had nothing to do. Error marks an operand access made while the unit was busy.

Top module: `seq_muldiv`

## Requirements
- R1: Address map: 0 to 5 are operand bytes OP0..OP5, 6 is shift control (bits 4:0 count, bit 5 direction), 7 is status (bit 0 done, bit 1 overflow, bit 2 error, bit 3 busy). Read data is registered and is valid on the cycle after `rd_en`. After reset, every register and flag reads zero.
- R2: Writing OP0, OP1, OP2, OP3, OP4, OP5 in that order launches a 32/16 divide. The dividend is OP3..OP0 (OP0 is the low byte) and the divisor is OP5:OP4. The quotient is returned in OP3..OP0 and the remainder in OP5:OP4.
- R3: Writing OP0, OP1, OP4, OP5 launches a 16/16 divide of OP1:OP0 by OP5:OP4. The quotient is returned in OP1:OP0 and the remainder in OP5:OP4.
- R4: Writing OP0, OP4, OP1, OP5 launches a multiply of OP1:OP0 by OP5:OP4. The 32-bit product is returned in OP3..OP0.
- R5: Writing OP0..OP3 and then the control byte with a nonzero count launches a shift of the 32-bit value by that many places. Direction 0 shifts left and 1 shifts right.
- R6: A control write with count zero launches a normalize. The value is shifted left until bit 31 is set, and the count field then holds the number of shifts made.
- R7: Overflow is set on a divisor of zero, on a product above 0000FFFFh, and on a normalize that starts with OP3 bit 7 set. Only a write to OP0 while idle clears it.
- R8: Done is cleared by the launching write and set when the result is written back. Busy reads 1 from the cycle after the launching write until write-back.
- R9: Any read or write of OP0..OP5 while busy sets error. Such writes are ignored. Error is cleared only by an operand read while idle.
- R10: A write order that matches none of the listed orders launches nothing. A write to OP0 always restarts the order tracking.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| done_o | output | 1 | Calculation finished |
| busy_o | output | 1 | Calculation in progress |

## Verification
The bench goes after order decoding. It sends a stray write before OP0 and also an incomplete order. A decoder that did not restart on OP0, or that launched on any write to OP5, would start a calculation or give a wrong product. It checks that the remainder returned by a divide by zero is still exact, and that a normalize counts exactly 19 shifts. A design off by one in its step counter would leave the value one place short. It checks a launch that clears done before the first step, a write made while busy that must not reach the result, and an error flag that status reads must not clear.

// File: rtl/smd_pkg.sv
package smd_pkg;
  localparam int BYTE_W = 8;
  localparam int NUM_MD = 6;
  localparam int ADDR_W = 3;
  localparam int WORD_W = 4 * BYTE_W;
  localparam int HALF_W = 2 * BYTE_W;
  localparam int SHC_W  = $clog2(WORD_W);
  localparam int CNT_W  = SHC_W + 1;
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(6);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(7);

  typedef enum logic [3:0] {
    SQ_IDLE, SQ_0, SQ_01, SQ_012, SQ_0123, SQ_01234, SQ_014, SQ_04, SQ_041
  } seq_e;

  typedef enum logic [2:0] {
    OP_DIV32, OP_DIV16, OP_MUL, OP_SHIFT, OP_NORM
  } op_e;
endpackage

// File: rtl/smd_order_decoder.sv
module smd_order_decoder
  import smd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_ok,
  input  logic [ADDR_W-1:0] waddr,
  output logic              launch,
  output logic              start_q,
  output op_e               start_op
);
  seq_e state, nxt;
  op_e  op_c;

  always_comb begin
    nxt    = state;
    launch = 1'b0;
    op_c   = OP_DIV32;
    if (wr_ok) begin
      nxt = SQ_IDLE;
      if (waddr == ADDR_W'(0)) nxt = SQ_0;
      else begin
        case (state)
          SQ_0:     if (waddr == ADDR_W'(1)) nxt = SQ_01;
                    else if (waddr == ADDR_W'(4)) nxt = SQ_04;
          SQ_01:    if (waddr == ADDR_W'(2)) nxt = SQ_012;
                    else if (waddr == ADDR_W'(4)) nxt = SQ_014;
          SQ_012:   if (waddr == ADDR_W'(3)) nxt = SQ_0123;
          SQ_0123:  if (waddr == ADDR_W'(4)) nxt = SQ_01234;
                    else if (waddr == A_CTRL) begin launch = 1'b1; op_c = OP_SHIFT; end
          SQ_01234: if (waddr == ADDR_W'(5)) begin launch = 1'b1; op_c = OP_DIV32; end
          SQ_014:   if (waddr == ADDR_W'(5)) begin launch = 1'b1; op_c = OP_DIV16; end
          SQ_04:    if (waddr == ADDR_W'(1)) nxt = SQ_041;
          SQ_041:   if (waddr == ADDR_W'(5)) begin launch = 1'b1; op_c = OP_MUL; end
          default:  nxt = SQ_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= SQ_IDLE;
      start_q  <= 1'b0;
      start_op <= OP_DIV32;
    end else begin
      state    <= nxt;
      start_q  <= launch;
      start_op <= op_c;
    end
  end
endmodule

// File: rtl/smd_engine.sv
module smd_engine
  import smd_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_ok,
  input  logic [ADDR_W-1:0]        waddr,
  input  logic [BYTE_W-1:0]        wdata,
  input  logic                     start,
  input  op_e                      start_op,
  output logic [NUM_MD*BYTE_W-1:0] md_flat,
  output logic [SHC_W-1:0]         shcnt,
  output logic                     shdir,
  output logic                     busy,
  output logic                     last,
  output logic                     ovf_hit
);
  localparam int QBYTES = WORD_W / BYTE_W;
  localparam logic [CNT_W-1:0] NORM_MAX = CNT_W'(WORD_W - 1);

  logic [BYTE_W-1:0] md [NUM_MD];
  logic [WORD_W-1:0] acc, wb;
  logic [HALF_W:0]   rem;
  logic [HALF_W-1:0] opnd;
  logic [CNT_W-1:0]  cnt;
  logic              dir_r;
  op_e               op;

  for (genvar g = 0; g < NUM_MD; g++) begin : g_flat
    assign md_flat[g*BYTE_W +: BYTE_W] = md[g];
  end

  logic [WORD_W-1:0] word_in;
  logic [HALF_W-1:0] half_lo, half_hi;
  assign word_in = md_flat[WORD_W-1:0];
  assign half_lo = md_flat[HALF_W-1:0];
  assign half_hi = md_flat[NUM_MD*BYTE_W-1 -: HALF_W];

  logic [HALF_W:0]   rs, div_rem_n, msum;
  logic              ge;
  logic [WORD_W-1:0] div_acc_n, mul_acc_n, sh_acc_n;

  always_comb begin
    rs        = {rem[HALF_W-1:0], acc[WORD_W-1]};
    ge        = rs >= {1'b0, opnd};
    div_rem_n = ge ? rs - {1'b0, opnd} : rs;
    div_acc_n = {acc[WORD_W-2:0], ge};
    msum      = {1'b0, acc[WORD_W-1:HALF_W]} + (acc[0] ? {1'b0, opnd} : '0);
    mul_acc_n = {msum, acc[HALF_W-1:1]};
    sh_acc_n  = dir_r ? (acc >> 1) : (acc << 1);
    case (op)
      OP_DIV32, OP_DIV16: wb = div_acc_n;
      OP_MUL:             wb = mul_acc_n;
      OP_SHIFT:           wb = sh_acc_n;
      default:            wb = acc;
    endcase
    if (op == OP_NORM) last = busy && (acc[WORD_W-1] || cnt == NORM_MAX);
    else               last = busy && (cnt == CNT_W'(1));
    ovf_hit = 1'b0;
    if (start) begin
      case (start_op)
        OP_DIV32, OP_DIV16: ovf_hit = (half_hi == '0);
        OP_SHIFT:           ovf_hit = (shcnt == '0) && md[QBYTES-1][BYTE_W-1];
        default:            ovf_hit = 1'b0;
      endcase
    end else if (last && op == OP_MUL) begin
      ovf_hit = |mul_acc_n[WORD_W-1:HALF_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_MD; i++) md[i] <= '0;
      acc <= '0; rem <= '0; opnd <= '0; cnt <= '0;
      dir_r <= 1'b0; op <= OP_DIV32; busy <= 1'b0;
      shcnt <= '0; shdir <= 1'b0;
    end else if (start) begin
      busy  <= 1'b1;
      op    <= start_op;
      dir_r <= shdir;
      rem   <= '0;
      case (start_op)
        OP_DIV32: begin acc <= word_in; opnd <= half_hi; cnt <= CNT_W'(WORD_W); end
        OP_DIV16: begin acc <= {half_lo, {HALF_W{1'b0}}}; opnd <= half_hi; cnt <= CNT_W'(HALF_W); end
        OP_MUL:   begin acc <= {{HALF_W{1'b0}}, half_hi}; opnd <= half_lo; cnt <= CNT_W'(HALF_W); end
        default: begin
          acc <= word_in;
          if (shcnt == '0) begin op <= OP_NORM; cnt <= '0; end
          else cnt <= CNT_W'(shcnt);
        end
      endcase
    end else if (busy) begin
      case (op)
        OP_DIV32, OP_DIV16: begin acc <= div_acc_n; rem <= div_rem_n; end
        OP_MUL:             acc <= mul_acc_n;
        OP_SHIFT:           acc <= sh_acc_n;
        default:            if (!last) acc <= acc << 1;
      endcase
      if (op == OP_NORM) begin
        if (!last) cnt <= cnt + CNT_W'(1);
      end else begin
        cnt <= cnt - CNT_W'(1);
      end
      if (last) begin
        busy <= 1'b0;
        for (int i = 0; i < QBYTES; i++)
          if (op != OP_DIV16 || i < QBYTES / 2) md[i] <= wb[i*BYTE_W +: BYTE_W];
        if (op == OP_DIV32 || op == OP_DIV16) begin
          md[NUM_MD-2] <= div_rem_n[BYTE_W-1:0];
          md[NUM_MD-1] <= div_rem_n[HALF_W-1:BYTE_W];
        end
        if (op == OP_NORM) shcnt <= cnt[SHC_W-1:0];
      end
    end else if (wr_ok) begin
      if (waddr < ADDR_W'(NUM_MD)) md[waddr] <= wdata;
      else if (waddr == A_CTRL) begin
        shcnt <= wdata[SHC_W-1:0];
        shdir <= wdata[SHC_W];
      end
    end
  end
endmodule

// File: rtl/smd_flags.sv
module smd_flags
  import smd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              launch,
  input  logic              fin,
  input  logic              ovf_hit,
  input  logic              busy_any,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  output logic              done,
  output logic              ovf,
  output logic              err
);
  logic md_acc;
  assign md_acc = addr < ADDR_W'(NUM_MD);

  always_ff @(posedge clk) begin
    if (rst) begin
      done <= 1'b0; ovf <= 1'b0; err <= 1'b0;
    end else begin
      if (launch)   done <= 1'b0;
      else if (fin) done <= 1'b1;
      if (ovf_hit) ovf <= 1'b1;
      else if (wr_en && !busy_any && addr == ADDR_W'(0)) ovf <= 1'b0;
      if (busy_any && (rd_en || wr_en) && md_acc) err <= 1'b1;
      else if (!busy_any && rd_en && md_acc)      err <= 1'b0;
    end
  end
endmodule

// File: rtl/seq_muldiv.sv
module seq_muldiv
  import smd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  output logic              done_o,
  output logic              busy_o
);
  logic launch, start_q, busy, last, ovf_hit, busy_any, wr_ok;
  logic done, ovf, err, shdir;
  op_e  start_op;
  logic [SHC_W-1:0]         shcnt;
  logic [NUM_MD*BYTE_W-1:0] md_flat;

  assign busy_any = busy | start_q;
  assign wr_ok    = wr_en & ~busy_any;

  smd_order_decoder u_dec (
    .clk, .rst, .wr_ok, .waddr(addr), .launch, .start_q, .start_op
  );

  smd_engine u_eng (
    .clk, .rst, .wr_ok, .waddr(addr), .wdata, .start(start_q), .start_op,
    .md_flat, .shcnt, .shdir, .busy, .last, .ovf_hit
  );

  smd_flags u_flg (
    .clk, .rst, .launch, .fin(last), .ovf_hit, .busy_any, .rd_en, .wr_en, .addr,
    .done, .ovf, .err
  );

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (rd_en) begin
      if (addr < ADDR_W'(NUM_MD)) rdata <= md_flat[addr*BYTE_W +: BYTE_W];
      else if (addr == A_CTRL)    rdata <= BYTE_W'({shdir, shcnt});
      else                        rdata <= BYTE_W'({busy_any, err, ovf, done});
    end
  end

  assign done_o = done;
  assign busy_o = busy_any;
endmodule

// File: rtl/smd_chk.sv
module smd_chk
  import smd_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic              rd_en,
  input logic              launch,
  input logic              busy_any,
  input logic              busy,
  input logic              done,
  input logic              ovf,
  input logic              err
);
  logic md_acc;
  assign md_acc = addr < ADDR_W'(NUM_MD);

  AST_LAUNCH_IDLE: assert property (@(posedge clk) disable iff (rst) launch |-> !busy_any); // R10
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (rst) launch |=> !done); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst) done |-> !busy); // R8
  AST_OVF_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !busy_any && addr == ADDR_W'(0)) |=> !ovf); // R7
  AST_ERR_SET: assert property (@(posedge clk) disable iff (rst)
    (busy_any && (rd_en || wr_en) && md_acc) |=> err); // R9
  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (err && !(rd_en && md_acc && !busy_any)) |=> err); // R9
endmodule

bind seq_muldiv smd_chk u_chk (
  .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
  .launch(launch), .busy_any(busy_any), .busy(busy), .done(done),
  .ovf(ovf), .err(err)
);

// File: tb/seq_muldiv_test.sv
`timescale 1ns/1ps
module seq_muldiv_test;
  logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic done_o, busy_o;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  seq_muldiv uut (.clk, .rst, .addr, .wr_en, .rd_en, .wdata, .rdata, .done_o, .busy_o);

  // op(3) a(32) b(16) exp0(32) exp1(16) eovf(1); op: 0 div32, 1 div16, 2 mul, 3 shift
  localparam int NV = 12;
  localparam logic [99:0] VEC [NV] = '{
    {3'd0, 32'h12345678, 16'h0100, 32'h00123456, 16'h0078, 1'b0},
    {3'd0, 32'h000186A0, 16'h0007, 32'h000037CD, 16'h0005, 1'b0},
    {3'd1, 32'h0000FFFF, 16'h0010, 32'h00000FFF, 16'h000F, 1'b0},
    {3'd1, 32'h00001234, 16'h0000, 32'h0000FFFF, 16'h1234, 1'b1},
    {3'd2, 32'h00000012, 16'h0034, 32'h000003A8, 16'h0000, 1'b0},
    {3'd2, 32'h00001234, 16'h0100, 32'h00123400, 16'h0000, 1'b1},
    {3'd2, 32'h0000FFFF, 16'hFFFF, 32'hFFFE0001, 16'h0000, 1'b1},
    {3'd3, 32'h0F0000F1, 16'h0004, 32'hF0000F10, 16'h0004, 1'b0},
    {3'd3, 32'h80000001, 16'h0028, 32'h00800000, 16'h0028, 1'b0},
    {3'd3, 32'h00001000, 16'h0000, 32'h80000000, 16'h0013, 1'b0},
    {3'd3, 32'h80000005, 16'h0000, 32'h80000005, 16'h0000, 1'b1},
    {3'd3, 32'h00000001, 16'h001F, 32'h80000000, 16'h001F, 1'b0}
  };
  localparam string VREQ [4] = '{"R2", "R3", "R4", "R5/R6"};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    for (int i = 0; i < 200; i++) begin
      rd(3'd7, s);
      if (!s[3]) break;
    end
  endtask

  task automatic launch_op(input int op, input logic [31:0] a, input logic [15:0] b);
    case (op)
      0: begin wr(0, a[7:0]); wr(1, a[15:8]); wr(2, a[23:16]); wr(3, a[31:24]); wr(4, b[7:0]); wr(5, b[15:8]); end
      1: begin wr(0, a[7:0]); wr(1, a[15:8]); wr(4, b[7:0]); wr(5, b[15:8]); end
      2: begin wr(0, a[7:0]); wr(4, b[7:0]); wr(1, a[15:8]); wr(5, b[15:8]); end
      default: begin wr(0, a[7:0]); wr(1, a[15:8]); wr(2, a[23:16]); wr(3, a[31:24]); wr(6, b[7:0]); end
    endcase
  endtask

  task automatic read_word(output logic [31:0] w);
    logic [7:0] b0, b1, b2, b3;
    rd(0, b0); rd(1, b1); rd(2, b2); rd(3, b3);
    w = {b3, b2, b1, b0};
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [7:0] s, b4, b5;
    logic [31:0] w;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(7, s); chk("R1 status", {24'h0, s}, 32'h0);
    rd(0, s); chk("R1 op0", {24'h0, s}, 32'h0);
    rd(6, s); chk("R1 ctrl", {24'h0, s}, 32'h0);

    // R10 bad orders start nothing
    wr(0, 8'h11); wr(5, 8'h22);
    repeat (3) @(negedge clk);
    rd(7, s); chk("R10 no launch", {24'h0, s}, 32'h0);
    wr(0, 8'h11); wr(1, 8'h00); wr(5, 8'h00);
    repeat (3) @(negedge clk);
    rd(7, s); chk("R10 partial order", {24'h0, s}, 32'h0);
    // R10 stray write then OP0 restarts a multiply
    wr(2, 8'h77); launch_op(2, 32'd3, 16'd5); wait_idle();
    read_word(w); chk("R10 restart mul", w, 32'd15);

    foreach (VEC[v]) begin
      int op;
      op = int'(VEC[v][99:97]);
      launch_op(op, VEC[v][96:65], VEC[v][64:49]);
      wait_idle();
      read_word(w);
      if (op == 1) chk(VREQ[op], {16'h0, w[15:0]}, VEC[v][48:17]);
      else         chk(VREQ[op], w, VEC[v][48:17]);
      if (op <= 1) begin
        rd(4, b4); rd(5, b5);
        chk(op == 0 ? "R2 remainder" : "R3 remainder", {16'h0, b5, b4}, {16'h0, VEC[v][16:1]});
      end else if (op == 3) begin
        rd(6, b4);
        chk("R6 ctrl count", {24'h0, b4}, {16'h0, VEC[v][16:1]});
      end
      rd(7, s);
      chk("R7 overflow", {31'h0, s[1]}, {31'h0, VEC[v][0]});
    end

    // R9 access during busy sets error, write ignored
    launch_op(0, 32'd100, 16'd10);
    rd(0, s);
    wr(1, 8'hAA);
    rd(7, s); chk("R9 err while busy", {28'h0, s[3:2]}, 32'h3);
    wait_idle();
    rd(7, s); chk("R9 err kept by status read", {24'h0, s}, 32'h05);
    rd(1, s); chk("R9 busy write ignored", {24'h0, s}, 32'h0);
    rd(7, s); chk("R9 err cleared by idle read", {24'h0, s}, 32'h01);

    // R8 done cleared by launch, busy visible next cycle
    launch_op(1, 32'd50, 16'd7);
    rd(7, s); chk("R8 done cleared busy set", {24'h0, s}, 32'h08);
    wait_idle();
    rd(7, s); chk("R8 done set", {24'h0, s}, 32'h01);
    rd(0, s); chk("R3 small quotient", {24'h0, s}, 32'd7);

    // R7 overflow cleared by OP0 write
    launch_op(2, 32'hFFFF, 16'd2); wait_idle();
    rd(7, s); chk("R7 mul overflow", {31'h0, s[1]}, 32'h1);
    wr(0, 8'h00);
    rd(7, s); chk("R7 cleared by op0", {31'h0, s[1]}, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule